// File: doc/BRIEF.md
# Dual-Rail Half Adder with Biased Indication

This block adds two single-bit operands carried on dual-rail wires and produces a dual-rail sum and a dual-rail carry. Each operand arrives as a pair of rails: one rail asserted means the operand holds a value, and both rails at the resting level mean the operand is a spacer that separates successive values. The block is meant to sit inside an array of adders. Its sum output proves that both operands have arrived, and also that both have been withdrawn. Its carry output does not wait for this and may resolve as soon as the operands that are present fix its value.

The sum is built from four rendezvous elements, one for each combination of a rail of X with a rail of Y. A rendezvous element moves to a level only when both of its inputs agree on that level, and otherwise holds its state. In this block each rendezvous element samples its inputs on the clock, so the sum follows the operands one cycle later. The carry is plain combinational logic with no storage.

A parameter selects the resting convention. In return-to-zero mode the spacer is both rails low and a value raises one rail. In return-to-one mode the spacer is both rails high and a value lowers one rail. In that mode every combining gate is swapped for its dual, while the rendezvous elements stay the same.

Top module: `dr_half_adder`

## Requirements
- R1: While rst_ni is low and after it rises with both operands at spacer, sum_o rests at spacer: 2'b00 in return-to-zero mode (rto_mode_p=0) and 2'b11 in return-to-one mode (rto_mode_p=1).
- R2: Bit 1 of each pair is the true rail and bit 0 the false rail. In return-to-zero mode, value 1 is 2'b10 and value 0 is 2'b01. In return-to-one mode, value 1 is 2'b01, value 0 is 2'b10 and the spacer is 2'b11.
- R3: One clock edge after both operands carry values, sum_o carries the value X xor Y.
- R4: sum_o stays at spacer while either operand is at spacer, even when the other operand already carries a value.
- R5: Once sum_o carries a value, it keeps that value while either operand still carries a value. It returns to spacer one clock edge after both operands are at spacer.
- R6: carry_o is combinational. When both operands carry values, it shows X and Y in the same cycle.
- R7: carry_o shows value 0 in the same cycle that either operand carries value 0, even while the other operand is still at spacer (early resolution).
- R8: carry_o is at spacer whenever neither operand carries value 0 and at least one operand is at spacer.
- R9: sum_o never has both rails at the asserted level at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the rendezvous elements |
| rst_ni | input | 1 | Asynchronous active-low reset; puts the sum at spacer |
| x_i | input | 2 | Operand X, dual-rail {true, false} |
| y_i | input | 2 | Operand Y, dual-rail {true, false} |
| sum_o | output | 2 | Sum, dual-rail {true, false}; changes one edge after its operands |
| carry_o | output | 2 | Carry, dual-rail {true, false}; combinational |

## Verification
The carry is due in the same cycle as the operands that fix it. The sum is due after exactly one rising edge once its operand condition holds. The bench drives every operand change at a falling edge and queues the expected sum and carry for that step. A monitor then compares both at two nanoseconds after the next rising edge, where the carry has long settled and the sum has just been captured. The bench applies each operand combination with X first and again with Y first, withdraws the operands one at a time, and checks an instance of each mode against the same expected values, which are expressed in terms of asserted rails.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] rail_t;
  localparam int unsigned TRUE_IDX  = 1;
  localparam int unsigned FALSE_IDX = 0;
endpackage

// File: rtl/dr_celem.sv
// Two-input rendezvous element, sampled on the clock.
module dr_celem #(
  parameter bit rst_val_p = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= rst_val_p;
    else if (a_i && b_i)      q_o <= 1'b1;
    else if (!a_i && !b_i)    q_o <= 1'b0;
  end

  a_r1_celem_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != b_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/dr_gate.sv
// Two-input combining gate; return-to-one mode takes the dual.
module dr_gate #(
  parameter bit rto_mode_p = 1'b0,
  parameter bit is_or_p    = 1'b1
) (
  input  logic a_i,
  input  logic b_i,
  output logic o_o
);
  localparam bit use_or_c = is_or_p ^ rto_mode_p;

  if (use_or_c) begin : g_or
    assign o_o = a_i | b_i;
  end else begin : g_and
    assign o_o = a_i & b_i;
  end
endmodule

// File: rtl/dr_half_adder.sv
module dr_half_adder
  import dr_pkg::*;
#(
  parameter bit rto_mode_p = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] x_i,
  input  logic [1:0] y_i,
  output logic [1:0] sum_o,
  output logic [1:0] carry_o
);
  localparam bit sp_c = rto_mode_p;

  // Minterms: [0] xt&yf, [1] xf&yt (odd); [2] xt&yt, [3] xf&yf (even)
  logic [3:0] term_a, term_b, term_q;
  assign term_a = {x_i[FALSE_IDX], x_i[TRUE_IDX], x_i[FALSE_IDX], x_i[TRUE_IDX]};
  assign term_b = {y_i[FALSE_IDX], y_i[TRUE_IDX], y_i[TRUE_IDX],  y_i[FALSE_IDX]};

  for (genvar i = 0; i < 4; i++) begin : g_term
    dr_celem #(.rst_val_p(sp_c)) u_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (term_a[i]),
      .b_i   (term_b[i]),
      .q_o   (term_q[i])
    );
  end

  dr_gate #(.rto_mode_p(rto_mode_p), .is_or_p(1'b1)) u_sum_t (
    .a_i(term_q[0]), .b_i(term_q[1]), .o_o(sum_o[TRUE_IDX]));
  dr_gate #(.rto_mode_p(rto_mode_p), .is_or_p(1'b1)) u_sum_f (
    .a_i(term_q[2]), .b_i(term_q[3]), .o_o(sum_o[FALSE_IDX]));

  // Carry is free of indication and resolves early
  dr_gate #(.rto_mode_p(rto_mode_p), .is_or_p(1'b0)) u_cry_t (
    .a_i(x_i[TRUE_IDX]), .b_i(y_i[TRUE_IDX]), .o_o(carry_o[TRUE_IDX]));
  dr_gate #(.rto_mode_p(rto_mode_p), .is_or_p(1'b1)) u_cry_f (
    .a_i(x_i[FALSE_IDX]), .b_i(y_i[FALSE_IDX]), .o_o(carry_o[FALSE_IDX]));

  // Checks, in asserted-rail terms
  rail_t x_act, y_act, s_act, c_act;
  assign x_act = rto_mode_p ? ~x_i     : x_i;
  assign y_act = rto_mode_p ? ~y_i     : y_i;
  assign s_act = rto_mode_p ? ~sum_o   : sum_o;
  assign c_act = rto_mode_p ? ~carry_o : carry_o;

  logic x_sp, y_sp, x_dat, y_dat;
  assign x_sp  = (x_act == 2'b00);
  assign y_sp  = (y_act == 2'b00);
  assign x_dat = ^x_act;
  assign y_dat = ^y_act;

  a_r9_sum_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_act));

  a_r3_sum_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_dat && y_dat) |=>
      (s_act == {$past(x_act[1]) ^ $past(y_act[1]), ~($past(x_act[1]) ^ $past(y_act[1]))}));

  a_r4_sum_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((x_sp || y_sp) && s_act == 2'b00) |=> (s_act == 2'b00));

  a_r5_sum_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((x_dat || y_dat) && $onehot(s_act)) |=> $stable(sum_o));

  a_r7_carry_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_act == 2'b01 || y_act == 2'b01) |-> (c_act == 2'b01));

  a_r6_carry_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_act == 2'b10 && y_act == 2'b10) |-> (c_act == 2'b10));
endmodule

// File: tb/sim_dr_half_adder.sv
module sim_dr_half_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] xa = 2'b00, ya = 2'b00;
  logic [1:0] sum_z, cry_z, sum_o1, cry_o1;

  dr_half_adder #(.rto_mode_p(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xa), .y_i(ya), .sum_o(sum_z), .carry_o(cry_z));
  dr_half_adder #(.rto_mode_p(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(~xa), .y_i(~ya), .sum_o(sum_o1), .carry_o(cry_o1));

  typedef struct {
    logic [1:0] sum_a;
    logic [1:0] cry_a;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [1:0] sum_model = 2'b00;

  function automatic logic [1:0] enc(input bit v);
    return {v, ~v};
  endfunction

  task automatic step(input logic [1:0] x, input logic [1:0] y, input string tag);
    exp_t e;
    @(negedge clk);
    xa = x;
    ya = y;
    if ((^x) && (^y))              sum_model = enc(x[1] ^ y[1]);
    else if (x == 2'b00 && y == 2'b00) sum_model = 2'b00;
    e.sum_a = sum_model;
    e.cry_a = {x[1] & y[1], x[0] | y[0]};
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input logic [1:0] act, input logic [1:0] exp, input string what,
                     input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Monitor: R2 checks each mode against its own encoding
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(sum_z,  e.sum_a,  "rtz sum",   e.tag);
        cmp(cry_z,  e.cry_a,  "rtz carry", e.tag);
        cmp(sum_o1, ~e.sum_a, "rto sum R2", e.tag);
        cmp(cry_o1, ~e.cry_a, "rto carry R2", e.tag);
      end
    end
  end

  initial begin
    step(2'b00, 2'b00, "R1 reset");
    step(2'b00, 2'b00, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 2'b00, "R1 after reset");
    for (int order = 0; order < 2; order++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          logic [1:0] ex, ey;
          ex = enc(a[0]);
          ey = enc(b[0]);
          if (order == 0) begin
            step(ex, 2'b00, "R4 R7 R8 x first");
            step(ex, ey,    "R3 R6 both data");
            step(2'b00, ey, "R5 R7 R8 x withdrawn");
            step(2'b00, 2'b00, "R5 R8 both spacer");
          end else begin
            step(2'b00, ey, "R4 R7 R8 y first");
            step(ex, ey,    "R3 R6 both data");
            step(ex, 2'b00, "R5 R7 R8 y withdrawn");
            step(2'b00, 2'b00, "R5 R8 both spacer");
          end
          step(2'b00, 2'b00, "R9 idle");
        end
      end
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule